// File: doc/BRIEF.md
# Speculative Cache Address Generator

This block builds a memory address from a base operand and an index operand and hands the cache a fast guess at that address in the same cycle as the request, before a full carry-propagate adder could settle. Two cheap guesses are offered: a bitwise OR of the operands, which is correct whenever they share no set bit, and a segmented add in which carries never leave an 8-bit group, which is correct whenever no group below the top one overflows.

The true sum is always formed as well, from copies of the operands captured on the request. When the guess differs from the true sum, the block raises a replay flag on the following cycle and presents the corrected address, so the cache can reissue the lookup. A wrong guess is therefore never left standing. Two saturating counters record how often the guess was right and how often a replay was needed, so the benefit of each mode can be measured.

Top module: `spec_agen`

## Requirements
- R1: With mode 2'b01 and req_vld high, spec_addr equals base | index in the same cycle.
- R2: With mode 2'b10 and req_vld high, spec_addr is formed by adding each aligned 8-bit group of base and index on its own, with no carry entering a group and each group's carry-out dropped.
- R3: With mode 2'b00 or 2'b11, spec_addr equals base + index (modulo 2^64) and replay never follows.
- R4: spec_vld equals req_vld in the same cycle.
- R5: replay is high in the cycle after a request exactly when that request's spec_addr differed from base + index; otherwise replay is low.
- R6: In the cycle after a request, fix_addr equals base + index of that request.
- R7: fix_addr holds its value through cycles with req_vld low, whatever base and index do meanwhile.
- R8: hit_cnt increments by one in the cycle after each request in mode 2'b01 or 2'b10 whose guess was correct.
- R9: replay_cnt increments by one in the cycle after each request that causes a replay.
- R10: Both counters stop at their all-ones value and stay there.
- R11: While rst_n is low, replay, hit_cnt, replay_cnt and fix_addr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Address request strobe |
| mode | input | 2 | 00 full add, 01 OR guess, 10 segmented guess, 11 full add |
| base | input | ADDR_W | Base operand |
| index | input | ADDR_W | Index or offset operand |
| spec_vld | output | 1 | Fast address valid |
| spec_addr | output | ADDR_W | Fast (possibly wrong) address |
| replay | output | 1 | Previous request's fast address was wrong |
| fix_addr | output | ADDR_W | True sum of the last request's operands |
| hit_cnt | output | CNT_W | Correct guesses, saturating |
| replay_cnt | output | CNT_W | Replays, saturating |

## Verification
The assertions assume base, index and mode are steady from just after one clock edge until the next, so that the guess shown during a request cycle is the one the captured operands describe; the stimulus only changes inputs at the falling edge. They also assume the counters start from zero after reset. Stimulus mixes operands with disjoint bits, operands rich in group overflows, all-ones patterns and idle cycles in which the operands wander, and the counter width is narrowed so that both counters reach their ceiling.

// File: rtl/spec_agen_pkg.sv
package spec_agen_pkg;
  typedef enum logic [1:0] {
    AG_FULL  = 2'b00,
    AG_OR    = 2'b01,
    AG_SHORT = 2'b10,
    AG_RSVD  = 2'b11
  } ag_mode_e;
endpackage

// File: rtl/spec_agen_fast.sv
module spec_agen_fast
  import spec_agen_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int GRP_W  = 8
) (
  input  logic [ADDR_W-1:0] opa,
  input  logic [ADDR_W-1:0] opb,
  input  ag_mode_e          mode,
  output logic [ADDR_W-1:0] fast_addr,
  output logic              fast_err,
  output logic              fast_spec
);
  localparam int NGRP = ADDR_W / GRP_W;
  localparam logic [NGRP-1:0] LOW_MASK = {1'b0, {(NGRP-1){1'b1}}};

  logic [ADDR_W-1:0] or_addr;
  logic [ADDR_W-1:0] seg_addr;
  logic [ADDR_W-1:0] full_addr;
  logic [NGRP-1:0]   grp_cout;
  logic              or_err;
  logic              seg_err;

  assign or_addr   = opa | opb;
  assign full_addr = opa + opb;
  assign or_err    = |(opa & opb);

  for (genvar g = 0; g < NGRP; g++) begin : g_seg
    logic [GRP_W:0] gsum;
    assign gsum = {1'b0, opa[g*GRP_W +: GRP_W]} + {1'b0, opb[g*GRP_W +: GRP_W]};
    assign seg_addr[g*GRP_W +: GRP_W] = gsum[GRP_W-1:0];
    assign grp_cout[g] = gsum[GRP_W];
  end

  assign seg_err = |(grp_cout & LOW_MASK);

  always_comb begin
    fast_addr = full_addr;
    fast_err  = 1'b0;
    fast_spec = 1'b0;
    unique case (mode)
      AG_OR: begin
        fast_addr = or_addr;
        fast_err  = or_err;
        fast_spec = 1'b1;
      end
      AG_SHORT: begin
        fast_addr = seg_addr;
        fast_err  = seg_err;
        fast_spec = 1'b1;
      end
      default: begin
        fast_addr = full_addr;
        fast_err  = 1'b0;
        fast_spec = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/spec_agen_replay.sv
module spec_agen_replay #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic              req_err,
  input  logic [ADDR_W-1:0] opa,
  input  logic [ADDR_W-1:0] opb,
  output logic              replay,
  output logic [ADDR_W-1:0] fix_addr
);
  logic [ADDR_W-1:0] opa_q, opa_d;
  logic [ADDR_W-1:0] opb_q, opb_d;
  logic              rep_q, rep_d;

  always_comb begin
    opa_d = opa_q;
    opb_d = opb_q;
    rep_d = 1'b0;
    if (req_vld) begin
      opa_d = opa;
      opb_d = opb;
      rep_d = req_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_q <= '0;
      opb_q <= '0;
      rep_q <= 1'b0;
    end else begin
      opa_q <= opa_d;
      opb_q <= opb_d;
      rep_q <= rep_d;
    end
  end

  assign replay   = rep_q;
  assign fix_addr = opa_q + opb_q;

  assert_fix_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_vld) |-> $stable(fix_addr));
  assert_replay_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    replay |-> $past(req_vld));
endmodule

// File: rtl/spec_agen_stats.sv
module spec_agen_stats #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_inc,
  input  logic             rep_inc,
  output logic [CNT_W-1:0] hit_cnt,
  output logic [CNT_W-1:0] replay_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] hit_q, hit_d;
  logic [CNT_W-1:0] rep_q, rep_d;
  logic             hit_en, rep_en;

  assign hit_en = hit_inc && (hit_q != CNT_MAX);
  assign rep_en = rep_inc && (rep_q != CNT_MAX);

  always_comb begin
    hit_d = hit_q;
    rep_d = rep_q;
    if (hit_en) hit_d = hit_q + 1'b1;
    if (rep_en) rep_d = rep_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= '0;
      rep_q <= '0;
    end else begin
      hit_q <= hit_d;
      rep_q <= rep_d;
    end
  end

  assign hit_cnt    = hit_q;
  assign replay_cnt = rep_q;

  assert_hit_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q == CNT_MAX) |=> (hit_q == CNT_MAX));
  assert_rep_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_q == CNT_MAX) |=> (rep_q == CNT_MAX));
  assert_hit_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hit_inc) || $stable(hit_q));
  assert_rep_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rep_inc) || $stable(rep_q));
endmodule

// File: rtl/spec_agen.sv
module spec_agen
  import spec_agen_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int GRP_W  = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  output logic              spec_vld,
  output logic [ADDR_W-1:0] spec_addr,
  output logic              replay,
  output logic [ADDR_W-1:0] fix_addr,
  output logic [CNT_W-1:0]  hit_cnt,
  output logic [CNT_W-1:0]  replay_cnt
);
  ag_mode_e mode_e;
  logic     fast_err;
  logic     fast_spec;
  logic     hit_inc;
  logic     rep_inc;

  assign mode_e = ag_mode_e'(mode);

  spec_agen_fast #(.ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_fast (
    .opa       (base),
    .opb       (index),
    .mode      (mode_e),
    .fast_addr (spec_addr),
    .fast_err  (fast_err),
    .fast_spec (fast_spec)
  );

  spec_agen_replay #(.ADDR_W(ADDR_W)) u_replay (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (req_vld),
    .req_err  (fast_err),
    .opa      (base),
    .opb      (index),
    .replay   (replay),
    .fix_addr (fix_addr)
  );

  assign spec_vld = req_vld;
  assign hit_inc  = req_vld && fast_spec && !fast_err;
  assign rep_inc  = req_vld && fast_err;

  spec_agen_stats #(.CNT_W(CNT_W)) u_stats (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_inc    (hit_inc),
    .rep_inc    (rep_inc),
    .hit_cnt    (hit_cnt),
    .replay_cnt (replay_cnt)
  );

  // guess wrong <=> replay, judged against the registered true sum
  assert_replay_iff_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(spec_vld) |-> (replay == (fix_addr != $past(spec_addr))));
  assert_full_no_replay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_vld && (mode == 2'b00 || mode == 2'b11)) |=> !replay);
  assert_seg_err_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_vld && mode == 2'b10) |-> (fast_err == (spec_addr != base + index)));
  assert_or_err_matches_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_vld && mode == 2'b01) |-> (fast_err == (spec_addr != base + index)));
endmodule

// File: tb/spec_agen_tb.sv
module spec_agen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 64;
  localparam int GW = 8;
  localparam int CW = 8;
  localparam int NG = AW / GW;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_vld;
  logic [1:0]    mode;
  logic [AW-1:0] base, index;
  logic          spec_vld, replay;
  logic [AW-1:0] spec_addr, fix_addr;
  logic [CW-1:0] hit_cnt, replay_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic          exp_rep;
  logic [AW-1:0] exp_fix;
  int            exp_hit, exp_repc;

  spec_agen #(.ADDR_W(AW), .GRP_W(GW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .mode(mode),
    .base(base), .index(index), .spec_vld(spec_vld), .spec_addr(spec_addr),
    .replay(replay), .fix_addr(fix_addr), .hit_cnt(hit_cnt), .replay_cnt(replay_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [AW-1:0] model_fast(logic [AW-1:0] a, logic [AW-1:0] b, logic [1:0] m);
    logic [AW-1:0] r;
    logic [GW:0]   s;
    if (m == 2'b01) return a | b;
    if (m == 2'b10) begin
      r = '0;
      for (int g = 0; g < NG; g++) begin
        s = {1'b0, a[g*GW +: GW]} + {1'b0, b[g*GW +: GW]};
        r[g*GW +: GW] = s[GW-1:0];
      end
      return r;
    end
    return a + b;
  endfunction

  task automatic chk(bit ok, string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // after a posedge: compare registered outputs with the model
  task automatic check_regs();
    chk(replay == exp_rep, "R5 replay", AW'(replay), AW'(exp_rep));
    chk(fix_addr == exp_fix, "R6/R7 fix_addr", fix_addr, exp_fix);
    chk(hit_cnt == CW'(exp_hit), "R8/R10 hit_cnt", AW'(hit_cnt), AW'(exp_hit));
    chk(replay_cnt == CW'(exp_repc), "R9/R10 replay_cnt", AW'(replay_cnt), AW'(exp_repc));
  endtask

  task automatic step(logic v, logic [1:0] m, logic [AW-1:0] a, logic [AW-1:0] b);
    logic [AW-1:0] f, s;
    logic          e;
    @(negedge clk);
    check_regs();
    req_vld = v; mode = m; base = a; index = b;
    #1;
    f = model_fast(a, b, m);
    s = a + b;
    e = (f != s);
    chk(spec_vld == v, "R4 spec_vld", AW'(spec_vld), AW'(v));
    if (v) begin
      if (m == 2'b01)      chk(spec_addr == f, "R1 or guess", spec_addr, f);
      else if (m == 2'b10) chk(spec_addr == f, "R2 segmented guess", spec_addr, f);
      else                 chk(spec_addr == s, "R3 full add", spec_addr, s);
    end
    // model update for the coming edge
    exp_rep = v && e;
    if (v) begin
      exp_fix = s;
      if (e && exp_repc < int'(CMAX)) exp_repc++;
      if (!e && (m == 2'b01 || m == 2'b10) && exp_hit < int'(CMAX)) exp_hit++;
    end
  endtask

  function automatic logic [AW-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    logic [AW-1:0] a, b;
    rst_n = 1'b0; req_vld = 1'b0; mode = 2'b00; base = '1; index = '1;
    exp_rep = 1'b0; exp_fix = '0; exp_hit = 0; exp_repc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(replay == 1'b0 && hit_cnt == '0 && replay_cnt == '0, "R11 reset ctl",
        AW'({replay, hit_cnt, replay_cnt}), '0);
    chk(fix_addr == '0, "R11 reset fix_addr", fix_addr, '0);
    rst_n = 1'b1;

    // directed corners
    step(1, 2'b01, 64'h00F0, 64'h000F);             // disjoint OR: hit
    step(1, 2'b01, 64'h0001, 64'h0001);             // shared bit: replay
    step(1, 2'b10, 64'h00FF, 64'h0001);             // group 0 overflow: replay
    step(1, 2'b10, 64'hFF00_0000_0000_0000, 64'h0100_0000_0000_0000); // top group only: hit
    step(1, 2'b00, '1, 64'h1);                      // full add wraps
    step(1, 2'b11, 64'h1234, 64'h0FFF);             // reserved acts as full add
    step(0, 2'b01, rnd64(), rnd64());               // idle, fix must hold (R7)
    step(0, 2'b10, rnd64(), rnd64());
    step(1, 2'b10, '1, '1);                         // every group overflows

    // random mixed traffic
    for (int i = 0; i < 600; i++) begin
      a = rnd64(); b = rnd64();
      case ($urandom_range(0, 3))
        0: b = b & ~a;                              // disjoint bits
        1: b = b & 64'h0000_0000_0000_00FF;         // short offset
        2: begin a = a | 64'h8080_8080_8080_8080; b = b | 64'h8080_8080_8080_8080; end
        default: ;
      endcase
      step(logic'($urandom_range(0, 4) != 0), 2'($urandom_range(0, 3)), a, b);
    end

    // push both counters to their ceiling
    for (int i = 0; i < 300; i++) begin
      a = rnd64();
      step(1, 2'b01, a, rnd64() & ~a);
      step(1, 2'b01, a | 64'h1, 64'h1);
    end
    step(0, 2'b00, '0, '0);
    @(negedge clk);
    check_regs();
    chk(hit_cnt == CMAX, "R10 hit ceiling", AW'(hit_cnt), AW'(CMAX));
    chk(replay_cnt == CMAX, "R10 replay ceiling", AW'(replay_cnt), AW'(CMAX));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule